// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block groups two or three down-counting timer channels behind one small register window. A simple request port (valid, write, address, write data) reaches a shared output-control bit, a shared run register, or one channel's register block. Each bit of the run register starts or freezes one channel. Each channel has a reload value, a live count, a control word and its own interrupt line. The third channel is built only in the three-channel configuration, and only that channel carries an extra capture word.

A running channel decrements on each tick. The tick comes from a per-channel prescaler (dividing the clock by 4, 16, 64, 256 or 1024) or from an external tick strobe. When the count is already zero, the next tick reloads it and latches an underflow flag. That flag raises the channel's interrupt when the channel's interrupt enable is set. Read data comes back through a registered port one cycle after the request.

Top module: `tmu_timer_unit`

## Requirements
- R1: After synchronous reset, the run register, the output-control bit, every control word, every capture word and the read-data port are 0. Every reload and count word is 0xFFFF_FFFF, and all interrupt lines are low.
- R2: Word 0x00 holds only written bit 0 and reads it back in bit 0. When the output-control option is off, the word reads 0 and writes to it are ignored.
- R3: Word 0x04 stores the whole written value and reads it back unchanged. Bit n of the stored value runs channel n when 1 and freezes it when 0.
- R4: Channel blocks start at byte 0x20 (channel 2), 0x14 (channel 1) and 0x08 (channel 0), matched highest base first. Inside a block, local word 0 is the reload, word 1 the count, word 2 the control word and word 3 the capture word (channel 2 only, plain storage).
- R5: Reads of any undefined or unaligned address (address bits 1:0 not 00, or bytes 0x30 to 0x3F) return 0, and writes to them change nothing.
- R6: Control bits 2:0 select the tick. A value k from 0 to 4 gives one decrement every 4^(k+1) running cycles, counted from a prescaler that starts at 0 after reset and advances only while running. Values 6 and 7 give one decrement per cycle with ext_tick high. Value 5 never ticks.
- R7: A tick that sees a count of 0 loads the reload value and sets the underflow flag (control bit 8). A bus write to the count word in the same cycle takes precedence over the tick.
- R8: irq_o[n] is high while channel n's flag and its enable (control bit 5) are both 1. A control write with bit 8 at 0 clears the flag, and with bit 8 at 1 leaves it as it is. A write cannot set the flag.
- R9: A frozen channel holds its count and prescaler, and starting it again resumes from the held values.
- R10: In the two-channel configuration, addresses 0x20 and above read 0 and ignore writes, run bit 2 drives nothing, and irq_o[2] stays 0.
- R11: bus_rdata presents the addressed word on the cycle after a read request and keeps it until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_tick | input | 1 | External count strobe, one tick per high cycle |
| irq_o | output | 3 | Per-channel interrupt lines |

## Verification
Every result appears one clock edge after its cause. Read data is valid at the edge that takes the request. A count, flag or interrupt changes at the edge where a tick or a bus write is accepted. The bench drives stimulus on the falling edge and samples on the falling edge that follows the relevant rising edge. The prescaled test counts rising edges explicitly from the start write, and the division step of 4 predicts ticks on the 4th, 8th and later running edges. Checks on frozen channels and on ignored accesses read the affected word back through the bus, before any other stimulus can disturb it.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int CH_MAX      = 3;
    localparam int LIDX_W      = 3;
    localparam int OUTCTL_WORD = 0;
    localparam int START_WORD  = 1;
    localparam int CH_STRIDE   = 3;
    localparam int CH_FIRST    = 2;

    localparam int REG_RELOAD  = 0;
    localparam int REG_COUNT   = 1;
    localparam int REG_CTRL    = 2;
    localparam int REG_CAPT    = 3;

    localparam int CTRL_IE_BIT   = 5;
    localparam int CTRL_FLAG_BIT = 8;
    localparam int CTRL_PACK_W   = CTRL_FLAG_BIT + 1;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OUTCTL,
        TGT_START,
        TGT_CHAN
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [1:0]        ch;
        logic [LIDX_W-1:0] lidx;
    } decode_t;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [2:0] psel;
    } ctrl_t;

    // word index where a channel's register block begins
    function automatic int ch_base_word(input int ch);
        return CH_FIRST + CH_STRIDE * ch;
    endfunction

    function automatic logic [CTRL_PACK_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_PACK_W-1:0] w;
        w                = '0;
        w[2:0]           = c.psel;
        w[CTRL_IE_BIT]   = c.ie;
        w[CTRL_FLAG_BIT] = c.flag;
        return w;
    endfunction

endpackage

// File: rtl/tmu_addr_decode.sv
module tmu_addr_decode
    import tmu_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit HAS_CH2    = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int NUM_CH = HAS_CH2 ? CH_MAX : CH_MAX - 1;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              hit;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // highest channel base is matched first
    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.ch   = '0;
        dec.lidx = '0;
        hit      = 1'b0;
        if (aligned) begin
            for (int c = CH_MAX - 1; c >= 0; c--) begin
                if (!hit && int'(word) >= ch_base_word(c)) begin
                    hit = 1'b1;
                    if (c < NUM_CH) begin
                        dec.tgt  = TGT_CHAN;
                        dec.ch   = 2'(c);
                        dec.lidx = LIDX_W'(int'(word) - ch_base_word(c));
                    end
                end
            end
            if (!hit) begin
                if (int'(word) == START_WORD) begin
                    dec.tgt = TGT_START;
                end else if (HAS_OUTCTL && int'(word) == OUTCTL_WORD) begin
                    dec.tgt = TGT_OUTCTL;
                end
            end
        end
    end

endmodule

// File: rtl/tmu_prescaler.sv
module tmu_prescaler #(
    parameter int PRESC_W    = 10,
    parameter bit EXT_CLK_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] psel,
    input  logic       ext_tick,
    output logic       tick
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
        end else if (run) begin
            presc_q <= presc_q + PRESC_W'(1);
        end
    end

    always_comb begin
        mask = (PRESC_W'(1) << (2 * int'(psel) + 2)) - PRESC_W'(1);
        tick = 1'b0;
        case (psel)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: tick = run && ((presc_q & mask) == mask);
            3'd6, 3'd7:                   tick = run && ext_tick && EXT_CLK_EN;
            default:                      tick = 1'b0;
        endcase
    end

    // R9: a frozen channel keeps its prescaler phase
    a_r9_presc_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(presc_q));

endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PRESC_W    = 10,
    parameter bit HAS_CAPT   = 1'b0,
    parameter bit EXT_CLK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ext_tick,
    input  logic              sel,
    input  logic              wr,
    input  logic [LIDX_W-1:0] lidx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] capt_rd;
    logic              tick;
    logic              uf;
    logic              wr_reload;
    logic              wr_count;
    logic              wr_ctrl;

    assign wr_reload = sel && wr && (lidx == LIDX_W'(REG_RELOAD));
    assign wr_count  = sel && wr && (lidx == LIDX_W'(REG_COUNT));
    assign wr_ctrl   = sel && wr && (lidx == LIDX_W'(REG_CTRL));

    tmu_prescaler #(
        .PRESC_W    (PRESC_W),
        .EXT_CLK_EN (EXT_CLK_EN)
    ) i_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .psel     (ctrl_q.psel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    assign uf = tick && !wr_count && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
        end else if (wr_reload) begin
            reload_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '1;
        end else if (wr_count) begin
            count_q <= wdata;
        end else if (tick) begin
            count_q <= (count_q == '0) ? reload_q : count_q - DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.psel <= wdata[2:0];
            ctrl_q.ie   <= wdata[CTRL_IE_BIT];
            ctrl_q.flag <= (ctrl_q.flag & wdata[CTRL_FLAG_BIT]) | uf;
        end else if (uf) begin
            ctrl_q.flag <= 1'b1;
        end
    end

    generate
        if (HAS_CAPT) begin : g_capt
            logic [DATA_W-1:0] capt_q;
            logic              wr_capt;
            assign wr_capt = sel && wr && (lidx == LIDX_W'(REG_CAPT));
            always_ff @(posedge clk) begin
                if (rst) begin
                    capt_q <= '0;
                end else if (wr_capt) begin
                    capt_q <= wdata;
                end
            end
            assign capt_rd = capt_q;
        end else begin : g_no_capt
            assign capt_rd = '0;
        end
    endgenerate

    always_comb begin
        case (lidx)
            LIDX_W'(REG_RELOAD): rdata = reload_q;
            LIDX_W'(REG_COUNT):  rdata = count_q;
            LIDX_W'(REG_CTRL):   rdata = DATA_W'(ctrl_pack(ctrl_q));
            LIDX_W'(REG_CAPT):   rdata = capt_rd;
            default:             rdata = '0;
        endcase
    end

    assign irq = ctrl_q.flag & ctrl_q.ie;

    // R7: tick at zero reloads and raises the flag
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_count && count_q == '0) |=> (count_q == $past(reload_q)) && ctrl_q.flag);

    // R6: tick above zero decrements by exactly one
    a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_count && count_q != '0) |=> count_q == $past(count_q) - DATA_W'(1));

    // R9: frozen channel keeps its count
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> $stable(count_q));

    // R8: a control write never raises the flag by itself
    a_r8_no_set_by_write: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !uf && !ctrl_q.flag) |=> !ctrl_q.flag);

endmodule

// File: rtl/tmu_timer_unit.sv
module tmu_timer_unit
    import tmu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter int PRESC_W    = 10,
    parameter bit HAS_CH2    = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1,
    parameter bit EXT_CLK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    output logic [CH_MAX-1:0] irq_o
);

    localparam int NUM_CH = HAS_CH2 ? CH_MAX : CH_MAX - 1;

    decode_t           dec;
    logic [DATA_W-1:0] start_q;
    logic              outctl_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] ch_rdata [CH_MAX];
    logic              rd_req;
    logic              wr_req;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    tmu_addr_decode #(
        .ADDR_W     (ADDR_W),
        .HAS_CH2    (HAS_CH2),
        .HAS_OUTCTL (HAS_OUTCTL)
    ) i_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_req && dec.tgt == TGT_START) begin
            start_q <= bus_wdata;
        end
    end

    generate
        if (HAS_OUTCTL) begin : g_outctl
            always_ff @(posedge clk) begin
                if (rst) begin
                    outctl_q <= 1'b0;
                end else if (wr_req && dec.tgt == TGT_OUTCTL) begin
                    outctl_q <= bus_wdata[0];
                end
            end

            // R2: only bit 0 is kept
            a_r2_outctl_bit0: assert property (@(posedge clk) disable iff (rst)
                (wr_req && bus_addr == ADDR_W'(0)) |=> outctl_q == $past(bus_wdata[0]));
        end else begin : g_no_outctl
            assign outctl_q = 1'b0;
        end
    endgenerate

    generate
        for (genvar g = 0; g < CH_MAX; g++) begin : g_ch
            if (g < NUM_CH) begin : g_on
                logic sel;
                assign sel = bus_valid && (dec.tgt == TGT_CHAN) && (dec.ch == 2'(g));
                tmu_channel #(
                    .DATA_W     (DATA_W),
                    .PRESC_W    (PRESC_W),
                    .HAS_CAPT   (g == CH_MAX - 1),
                    .EXT_CLK_EN (EXT_CLK_EN)
                ) i_chan (
                    .clk      (clk),
                    .rst      (rst),
                    .run      (start_q[g]),
                    .ext_tick (ext_tick),
                    .sel      (sel),
                    .wr       (bus_write),
                    .lidx     (dec.lidx),
                    .wdata    (bus_wdata),
                    .rdata    (ch_rdata[g]),
                    .irq      (irq_o[g])
                );
            end else begin : g_off
                assign ch_rdata[g] = '0;
                assign irq_o[g]    = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        case (dec.tgt)
            TGT_OUTCTL: rd_word = DATA_W'(outctl_q);
            TGT_START:  rd_word = start_q;
            TGT_CHAN: begin
                for (int c = 0; c < CH_MAX; c++) begin
                    if (dec.ch == 2'(c)) rd_word = ch_rdata[c];
                end
            end
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_word;
        end
    end

    assign bus_rdata = rdata_q;

    // R3: run register keeps the whole written value
    a_r3_start_store: assert property (@(posedge clk) disable iff (rst)
        (wr_req && bus_addr == ADDR_W'(4)) |=> start_q == $past(bus_wdata));

    // R5: undefined addresses read as zero
    a_r5_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && dec.tgt == TGT_NONE) |=> bus_rdata == '0);

    // R11: read data holds between read requests
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(bus_rdata));

endmodule

// File: tb/test_tmu_timer_unit.sv
module test_tmu_timer_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_write;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;
    logic        ext_tick;
    logic [2:0]  irq_a;
    logic [2:0]  irq_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmu_timer_unit i_tmu_timer_unit (
        .clk (clk), .rst (rst), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_a),
        .ext_tick (ext_tick), .irq_o (irq_a)
    );

    tmu_timer_unit #(.HAS_CH2 (1'b0), .HAS_OUTCTL (1'b0)) i_tmu_timer_unit_two (
        .clk (clk), .rst (rst), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_b),
        .ext_tick (ext_tick), .irq_o (irq_b)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        int          req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h00, 32'hFFFF_FFFF, 2},  // R2 write all ones
        '{1'b0, 6'h00, 32'h0000_0001, 2},  // R2 only bit 0 kept
        '{1'b1, 6'h04, 32'hA5A5_0000, 3},  // R3 no run bits
        '{1'b0, 6'h04, 32'hA5A5_0000, 3},  // R3 read back whole value
        '{1'b1, 6'h08, 32'h1111_1111, 4},  // R4 ch0 reload
        '{1'b0, 6'h08, 32'h1111_1111, 4},
        '{1'b1, 6'h18, 32'h2222_2222, 4},  // R4 ch1 count
        '{1'b0, 6'h18, 32'h2222_2222, 4},
        '{1'b0, 6'h14, 32'hFFFF_FFFF, 4},  // R4 ch1 reload untouched
        '{1'b1, 6'h2C, 32'h3333_3333, 4},  // R4 ch2 capture
        '{1'b0, 6'h2C, 32'h3333_3333, 4},
        '{1'b1, 6'h10, 32'hFFFF_FFFF, 8},  // R8 ctrl write cannot set flag
        '{1'b0, 6'h10, 32'h0000_0027, 8},
        '{1'b1, 6'h30, 32'h4444_4444, 5},  // R5 write beyond channel 2 words
        '{1'b0, 6'h30, 32'h0000_0000, 5},
        '{1'b0, 6'h3C, 32'h0000_0000, 5},
        '{1'b0, 6'h20, 32'hFFFF_FFFF, 4},  // R4 ch2 reload at reset value
        '{1'b0, 6'h09, 32'h0000_0000, 5}   // R5 unaligned
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // all tasks are entered right after a falling edge
    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] da, output logic [31:0] db);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        da = rdata_a;
        db = rdata_b;
    endtask

    task automatic pulse_ext(input int n);
        ext_tick = 1'b1;
        repeat (n) @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb, hold;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; ext_tick = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        do_reset();

        // R1 reset outputs
        check("R1", rdata_a, 32'h0, "rdata after reset");
        check("R1", {29'd0, irq_a}, 32'h0, "irq after reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_wr(VECS[i].addr, VECS[i].data);
            end else begin
                bus_rd(VECS[i].addr, ra, rb);
                check($sformatf("R%0d", VECS[i].req), ra, VECS[i].data,
                      $sformatf("vector %0d addr 0x%02h", i, VECS[i].addr));
            end
        end

        // R1 register reset values
        do_reset();
        bus_rd(6'h04, ra, rb); check("R1", ra, 32'h0, "run reg reset");
        bus_rd(6'h0C, ra, rb); check("R1", ra, 32'hFFFF_FFFF, "ch0 count reset");
        bus_rd(6'h10, ra, rb); check("R1", ra, 32'h0, "ch0 ctrl reset");
        bus_rd(6'h00, ra, rb); check("R1", ra, 32'h0, "outctl reset");
        bus_rd(6'h2C, ra, rb); check("R1", ra, 32'h0, "ch2 capture reset");

        // R6 divide by 4: run for 20 edges, ticks on edges 4,8,12,16,20
        bus_wr(6'h0C, 32'd10);
        bus_wr(6'h04, 32'h1);
        repeat (19) @(negedge clk);
        bus_wr(6'h04, 32'h0);
        bus_rd(6'h0C, ra, rb); check("R6", ra, 32'd5, "ch0 count after 20 edges at /4");

        // R6 external ticks, R7 underflow reload, R8 irq
        bus_wr(6'h28, 32'h26);
        bus_wr(6'h20, 32'd3);
        bus_wr(6'h24, 32'd2);
        bus_wr(6'h04, 32'h4);
        pulse_ext(3);
        check("R8", {29'd0, irq_a}, 32'h4, "ch2 irq after underflow");
        check("R10", {29'd0, irq_b}, 32'h0, "two-channel irq with run bit 2");
        bus_rd(6'h24, ra, rb); check("R7", ra, 32'd3, "ch2 count reloaded");
        bus_rd(6'h28, ra, rb); check("R7", ra, 32'h126, "ch2 flag set");
        bus_wr(6'h28, 32'h026);
        check("R8", {29'd0, irq_a}, 32'h0, "flag cleared by writing bit 8 as 0");
        pulse_ext(4);
        check("R7", {29'd0, irq_a}, 32'h4, "second underflow after 4 ticks");
        bus_wr(6'h28, 32'h126);
        check("R8", {29'd0, irq_a}, 32'h4, "writing bit 8 as 1 keeps flag");
        bus_wr(6'h28, 32'h106);
        check("R8", {29'd0, irq_a}, 32'h0, "enable off masks irq");
        bus_rd(6'h28, ra, rb); check("R8", ra, 32'h106, "flag still stored");

        // R9 hold while frozen, resume after restart
        bus_wr(6'h04, 32'h0);
        pulse_ext(2);
        bus_rd(6'h24, ra, rb); check("R9", ra, 32'd3, "frozen count held");
        bus_wr(6'h04, 32'h4);
        pulse_ext(1);
        bus_wr(6'h04, 32'h0);
        bus_rd(6'h24, ra, rb); check("R9", ra, 32'd2, "resumed count");

        // R6 select 5 never ticks
        bus_wr(6'h1C, 32'h5);
        bus_wr(6'h18, 32'd7);
        bus_wr(6'h04, 32'h2);
        repeat (30) @(negedge clk);
        bus_wr(6'h04, 32'h0);
        bus_rd(6'h18, ra, rb); check("R6", ra, 32'd7, "select 5 holds count");

        // R10 two-channel window and R2 absent output control
        bus_wr(6'h20, 32'h55);
        bus_rd(6'h20, ra, rb);
        check("R4", ra, 32'h55, "ch2 reload written");
        check("R10", rb, 32'h0, "two-channel read at 0x20");
        bus_wr(6'h00, 32'hFF);
        bus_rd(6'h00, ra, rb);
        check("R2", ra, 32'h1, "outctl bit 0");
        check("R2", rb, 32'h0, "outctl absent reads 0");

        // R11 read data holds while idle
        bus_rd(6'h14, ra, rb);
        hold = ra;
        repeat (3) @(negedge clk);
        check("R11", rdata_a, hold, "rdata held while idle");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule